// File: doc/BRIEF.md
# Pseudorandom Heads/Tails Bit Generator

This block supplies a single pseudorandom bit that a processor's condition logic uses for random-rounding tests: a "heads" test is satisfied when the bit is 1 and a "tails" test when it is 0. The bit comes from a ten-stage maximal-length linear feedback shift register. Over one full period, ones and zeros appear in almost equal numbers.

The register moves forward by exactly one step each time a heads or tails test is evaluated, and holds its value at all other times. A write to the interrupt-return address register restarts the sequence from its seed as a side effect. The written value plays no part. This restart is suppressed while an interrupt service routine is running, and it is suppressed at all times while a mode bit that locks the sequence is set. The register file, the interrupt controller and the condition decoder sit outside this block; they provide the strobes and the flags.

Top module: `hto_rand_bit`

## Requirements
- R1: After reset, all ten stages hold 1 (the seed), so the output bit reads 1.
- R2: In a cycle with adv_i high and no restart, the register shifts one place toward stage 0. The new stage 9 takes stage 0 XOR stage 3, which is the recurrence of a maximal-length polynomial. The output is stage 0, a registered value, and it shows the new state one clock after the strobe.
- R3: In a cycle with adv_i low and no restart, the register and the output hold their values.
- R4: A restart happens when ret_wr_i is high while in_isr_i is low and rand_lock_i is low. All stages then load 1 at the next clock. The block has no data input, so the written value cannot matter.
- R5: While in_isr_i is high, ret_wr_i does not restart the sequence. An advance in the same cycle still takes place.
- R6: While rand_lock_i is high, ret_wr_i never restarts the sequence. An advance in the same cycle still takes place.
- R7: When a restart and an advance fall in the same cycle, the restart wins. The state becomes the seed and the output reads 1.
- R8: Starting from the seed, the output sequence repeats with period 1023. Each period contains 512 ones, and the register never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | A heads or tails test is evaluated this cycle |
| ret_wr_i | input | 1 | The interrupt-return address register is written this cycle |
| in_isr_i | input | 1 | An interrupt service routine is in progress |
| rand_lock_i | input | 1 | Mode bit that blocks every restart |
| rnd_bit_o | output | 1 | Current pseudorandom bit (1 = heads, 0 = tails) |

## Verification
The bench builds the block with its default parameters: a width of 10 and a feedback tap at stage 3. At that size a full period is only 1023 advances, so the bench can walk two complete periods. It confirms that the sequence repeats and counts the ones in each period. Restarts are placed after enough advances that a wrongly taken or wrongly suppressed restart shifts the position of the first tails in the sequence. This makes the interrupt-service and lock qualifiers, and the priority of restart over advance, visible at the output.

// File: rtl/hto_pkg.sv
package hto_pkg;

    localparam int unsigned DEF_WIDTH = 10;
    localparam int unsigned DEF_TAP   = 3;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_SEED = 2'd2
    } act_e;

endpackage

// File: rtl/hto_restart_qual.sv
module hto_restart_qual
    import hto_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic adv_i,
    input  logic ret_wr_i,
    input  logic in_isr_i,
    input  logic rand_lock_i,
    output act_e act_o
);

    logic restart_ok;

    always_comb begin
        restart_ok = ret_wr_i && !in_isr_i && !rand_lock_i;
        if (restart_ok) begin
            act_o = ACT_SEED;
        end else if (adv_i) begin
            act_o = ACT_STEP;
        end else begin
            act_o = ACT_HOLD;
        end
    end

    AST_ISR_NO_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_isr_i |-> act_o != ACT_SEED); // R5
    AST_LOCK_NO_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rand_lock_i |-> act_o != ACT_SEED); // R6

endmodule

// File: rtl/hto_lfsr_step.sv
module hto_lfsr_step #(
    parameter int unsigned WIDTH = hto_pkg::DEF_WIDTH,
    parameter int unsigned TAP   = hto_pkg::DEF_TAP
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);

    localparam int unsigned TOP = WIDTH - 1;

    initial begin
        if (TAP == 0 || TAP >= WIDTH) begin
            $error("hto_lfsr_step: TAP must lie between 1 and WIDTH-1");
        end
    end

    logic feedback;

    always_comb begin
        feedback = cur_i[0] ^ cur_i[TAP];
        nxt_o    = {feedback, cur_i[TOP:1]};
    end

endmodule

// File: rtl/hto_rand_bit.sv
module hto_rand_bit
    import hto_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter int unsigned TAP   = DEF_TAP
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic adv_i,
    input  logic ret_wr_i,
    input  logic in_isr_i,
    input  logic rand_lock_i,
    output logic rnd_bit_o
);

    localparam logic [WIDTH-1:0] SEED = {WIDTH{1'b1}};
    localparam int unsigned      TOP  = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] sreg;
    } gen_state_t;

    gen_state_t       st_d, st_q;
    act_e             act;
    logic [WIDTH-1:0] stepped;

    hto_restart_qual u_qual (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .adv_i       (adv_i),
        .ret_wr_i    (ret_wr_i),
        .in_isr_i    (in_isr_i),
        .rand_lock_i (rand_lock_i),
        .act_o       (act)
    );

    hto_lfsr_step #(
        .WIDTH (WIDTH),
        .TAP   (TAP)
    ) u_step (
        .cur_i (st_q.sreg),
        .nxt_o (stepped)
    );

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_SEED: st_d.sreg = SEED;
            ACT_STEP: st_d.sreg = stepped;
            default:  st_d      = st_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sreg <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign rnd_bit_o = st_q.sreg[0];

    AST_SEED_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_wr_i && !in_isr_i && !rand_lock_i) |=> st_q.sreg == SEED); // R4
    AST_SEED_BEATS_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && ret_wr_i && !in_isr_i && !rand_lock_i) |=> rnd_bit_o); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_i && !(ret_wr_i && !in_isr_i && !rand_lock_i)) |=> $stable(st_q.sreg)); // R3
    AST_ADV_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !(ret_wr_i && !in_isr_i && !rand_lock_i))
        |=> st_q.sreg[TOP-1:0] == $past(st_q.sreg[TOP:1])); // R2
    AST_NEVER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.sreg != '0); // R8

endmodule

// File: tb/sim_hto_rand_bit.sv
module sim_hto_rand_bit;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adv = 1'b0, wr = 1'b0, isr = 1'b0, lock = 1'b0;
    logic bit_o;
    int   checks = 0;
    int   failures = 0;

    always #5 clk = ~clk;

    hto_rand_bit u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .adv_i       (adv),
        .ret_wr_i    (wr),
        .in_isr_i    (isr),
        .rand_lock_i (lock),
        .rnd_bit_o   (bit_o)
    );

    // vector fields: {adv, wr, isr, lock, expected bit after the edge}
    localparam logic [4:0] VEC [0:27] = '{
        5'b10001, 5'b10001, 5'b00001, 5'b01101, 5'b01011,
        5'b10001, 5'b10001, 5'b10001, 5'b10001, 5'b10001, 5'b10001, 5'b10001,
        5'b10000, 5'b11100, 5'b10000, 5'b11010, 5'b01001,
        5'b11001,
        5'b10001, 5'b10001, 5'b10001, 5'b10001, 5'b10001, 5'b10001, 5'b10001,
        5'b10001, 5'b10001, 5'b10000
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cyc(input logic a, input logic w, input logic i, input logic l);
        adv = a; wr = w; isr = i; lock = l;
        @(negedge clk);
        adv = 1'b0; wr = 1'b0; isr = 1'b0; lock = 1'b0;
    endtask

    function automatic logic [9:0] model_step(input logic [9:0] s);
        return {s[0] ^ s[3], s[9:1]};
    endfunction

    logic [1022:0] first_period;
    logic [9:0]    mdl;
    int            ones;

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1 reset output", bit_o, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 output after reset release", bit_o, 1'b1);

        // table walk: advances, holds, blocked and taken restarts
        for (int k = 0; k < 28; k++) begin
            cyc(VEC[k][4], VEC[k][3], VEC[k][2], VEC[k][1]);
            if (k == 2)
                check("R3 idle hold", bit_o, VEC[k][0]);
            else if (k == 3 || k == 13)
                check("R5 isr blocks restart", bit_o, VEC[k][0]);
            else if (k == 4 || k == 15)
                check("R6 lock blocks restart", bit_o, VEC[k][0]);
            else if (k == 16)
                check("R4 restart loads seed", bit_o, VEC[k][0]);
            else if (k >= 17)
                check("R7 restart beats advance", bit_o, VEC[k][0]);
            else
                check("R2 advance sequence", bit_o, VEC[k][0]);
        end

        // reset mid-sequence brings back the seed
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", bit_o, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // two full periods from the seed
        mdl  = 10'h3FF;
        ones = 0;
        for (int n = 0; n < 1023; n++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0);
            mdl = model_step(mdl);
            first_period[n] = bit_o;
            if (bit_o) ones++;
            if (bit_o !== mdl[0]) check("R2 long sequence", bit_o, mdl[0]);
        end
        checks++;
        if (ones != 512) begin
            failures++;
            $display("FAIL R8 ones per period actual=%0d expected=512", ones);
        end
        check("R8 model returns to seed", mdl == 10'h3FF, 1'b1);
        for (int n = 0; n < 1023; n++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0);
            if (bit_o !== first_period[n]) check("R8 period repeat", bit_o, first_period[n]);
        end
        checks++;

        // a write with both qualifiers set is still blocked
        for (int n = 0; n < 9; n++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 1'b1);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 R6 both qualifiers block restart", bit_o, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule